// File: doc/BRIEF.md
# PCM Sample Format Converter

This block sits between a voice datapath that works on 16-bit two's-complement samples and a line interface that carries them as compressed or linear codes. Its transmit path turns each linear sample into a code, and its receive path turns each received code back into a linear sample. The two paths are independent pipelines. Each has a valid/ready handshake on its input and on its output, and each delivers one result per clock when its consumer keeps ready high.

A static two-bit format input selects one of four formats: mu-law companding, A-law companding, 16-bit linear pass-through, or 8-bit linear truncation. A second two-bit input controls how A-law code words are inverted, on both transmit and receive. A compressed code is one byte: a sign bit at the top, then a three-bit segment number, then a four-bit step within that segment. A code of 8 bits or fewer occupies bits [7:0] of the 16-bit code bus. The format inputs may change only while both pipelines are empty.

Top module: `pcm_fmt_conv`

## Requirements
- R1: After reset, neither output valid is asserted, and both input readies are high while the output consumers are ready.
- R2: With format 0 (mu-law), the transmit code is built as follows. Take the sample shifted right arithmetically by 2. Take its magnitude and clip it to 8158. Add a bias of 33. The segment is the leading-one position minus 5, and the step is the biased magnitude shifted right by segment+1, bits [3:0]. The byte {negative, segment, step} is fully inverted and placed in bits [7:0], and bits [15:8] are 0.
- R3: With format 1 (A-law), the magnitude is the sample shifted right arithmetically by 3, bitwise complemented when the sample is negative. A magnitude below 32 gives segment 0 and step equal to magnitude bits [4:1]. Any other magnitude gives a segment equal to its leading-one position minus 4. The step is then magnitude bits [4:1] for segment 1, and the magnitude shifted right by the segment, bits [3:0], for higher segments. The byte is {not negative, segment, step}, and bits [15:8] are 0.
- R4: A-law codes are XORed with a mask chosen by the inversion input: 0 gives 0x55 (even bits), 1 gives 0xFF (all bits), and 2 or 3 give 0x00. The receive path removes the same mask before expansion. The inversion input has no effect in mu-law mode.
- R5: Mu-law decoding works on the fully inverted received byte u. It forms t = (step*8 + 132) << segment, and the result is 132 - t when u[7] is 1, otherwise t - 132.
- R6: A-law decoding works on the unmasked byte. It forms t = step*16 + 8 for segment 0 and step*16 + 264 otherwise, shifted left by segment-1 when the segment exceeds 1. The result is t when bit 7 is 1, otherwise -t.
- R7: With format 2 (16-bit linear), both paths pass all 16 bits through unchanged.
- R8: With format 3 (8-bit linear), the transmit code is sample[15:8] in bits [7:0] with zero above it. The receive sample is code[7:0] in bits [15:8] with zero in bits [7:0].
- R9: A result appears on the output exactly 2 clock cycles after its input handshake when the output is kept ready, and a new input is accepted every cycle.
- R10: While an output is valid but not ready, its valid and data hold steady. No result is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Format: 0 mu-law, 1 A-law, 2 linear 16, 3 linear 8 |
| ainv_i | input | 2 | A-law inversion: 0 even bits, 1 all bits, 2/3 none |
| tx_in_valid_i | input | 1 | Transmit sample valid |
| tx_in_ready_o | output | 1 | Transmit path can accept a sample |
| tx_sample_i | input | 16 | Linear sample to encode |
| tx_out_valid_o | output | 1 | Transmit code valid |
| tx_out_ready_i | input | 1 | Transmit code consumer ready |
| tx_code_o | output | 16 | Encoded code |
| rx_in_valid_i | input | 1 | Received code valid |
| rx_in_ready_o | output | 1 | Receive path can accept a code |
| rx_code_i | input | 16 | Code to decode |
| rx_out_valid_o | output | 1 | Decoded sample valid |
| rx_out_ready_i | input | 1 | Decoded sample consumer ready |
| rx_sample_o | output | 16 | Decoded linear sample |

## Verification
On both paths, a result is due two rising edges after its input handshake. The bench watches handshakes at the falling edge. It records the cycle of each accepted input together with its expected result, and when the matching output handshake is seen it compares the result in order. In phases where the consumer is always ready, it also requires the gap between the two handshakes to be exactly two cycles. In the backpressure phase only value and order are checked. Each receive input is the expected transmit code, so every compared receive sample is a round trip of the sample.

// File: rtl/pcm_fmt_pkg.sv
package pcm_fmt_pkg;

    localparam int SMP_W    = 16;
    localparam int LAW_W    = 8;
    localparam int SEG_W    = 3;
    localparam int STEP_W   = 4;
    localparam int MU_MAG_W = 13;
    localparam int A_MAG_W  = 12;
    localparam int MU_BIAS  = 33;
    localparam int MU_CLIP  = 8158;
    localparam int MU_DBIAS = 132;
    localparam int PAD_W    = SMP_W - LAW_W;

    typedef enum logic [1:0] {
        FMT_MULAW = 2'd0,
        FMT_ALAW  = 2'd1,
        FMT_LIN16 = 2'd2,
        FMT_LIN8  = 2'd3
    } fmt_e;

    function automatic logic [LAW_W-1:0] inv_mask(input logic [1:0] sel);
        case (sel)
            2'd0:    return LAW_W'(8'h55);
            2'd1:    return LAW_W'(8'hFF);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/pcm_lead_one.sv
module pcm_lead_one #(
    parameter int W = 13,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [PW-1:0] pos_o
);
    always_comb begin
        pos_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) pos_o = PW'(i);
        end
    end
endmodule

// File: rtl/pcm_enc_pipe.sv
module pcm_enc_pipe
    import pcm_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fmt_i,
    input  logic [1:0]       inv_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [SMP_W-1:0] in_data_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [SMP_W-1:0] out_data_o
);
    typedef struct packed {
        logic                v;
        fmt_e                fmt;
        logic [1:0]          inv;
        logic                neg;
        logic [MU_MAG_W-1:0] mu_mag;
        logic [A_MAG_W-1:0]  a_mag;
        logic [SMP_W-1:0]    raw;
    } s1_t;

    typedef struct packed {
        logic             v;
        fmt_e             fmt;
        logic             neg;
        logic [SMP_W-1:0] data;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } st_t;

    st_t st_d, st_q;

    logic [3:0] mu_pos, a_pos;

    pcm_lead_one #(.W(MU_MAG_W)) u_mu_lead (.vec_i(st_q.s1.mu_mag), .pos_o(mu_pos));
    pcm_lead_one #(.W(A_MAG_W))  u_a_lead  (.vec_i(st_q.s1.a_mag),  .pos_o(a_pos));

    logic                    adv;
    logic signed [SMP_W-1:0] smp_s, sh_mu, sh_a;
    logic [SMP_W-1:0]        mu_abs, mu_clip, mu_bias, a_abs;
    logic [3:0]              mu_seg_w, a_seg_w, mu_shamt;
    logic [SEG_W-1:0]        mu_seg, a_seg;
    logic [MU_MAG_W-1:0]     mu_sh;
    logic [A_MAG_W-1:0]      a_sh;
    logic [LAW_W-1:0]        mu_code, a_code;
    logic [SMP_W-1:0]        code_c;

    always_comb begin
        st_d = st_q;
        adv  = !st_q.s2.v || out_ready_i;

        // stage 1: sign and magnitude for both laws
        smp_s   = $signed(in_data_i);
        sh_mu   = smp_s >>> 2;
        sh_a    = smp_s >>> 3;
        mu_abs  = in_data_i[SMP_W-1] ? (~sh_mu + 1'b1) : sh_mu;
        mu_clip = (mu_abs > SMP_W'(MU_CLIP)) ? SMP_W'(MU_CLIP) : mu_abs;
        mu_bias = mu_clip + SMP_W'(MU_BIAS);
        a_abs   = in_data_i[SMP_W-1] ? ~sh_a : sh_a;

        // stage 2: segment search, step extraction, code assembly
        mu_seg_w = mu_pos - 4'd5;
        mu_seg   = mu_seg_w[SEG_W-1:0];
        mu_shamt = {1'b0, mu_seg} + 4'd1;
        mu_sh    = st_q.s1.mu_mag >> mu_shamt;
        mu_code  = ~{st_q.s1.neg, mu_seg, mu_sh[STEP_W-1:0]};

        a_seg_w = a_pos - 4'd4;
        a_seg   = (st_q.s1.a_mag < A_MAG_W'(32)) ? '0 : a_seg_w[SEG_W-1:0];
        a_sh    = (a_seg < 3'd2) ? (st_q.s1.a_mag >> 1) : (st_q.s1.a_mag >> a_seg);
        a_code  = {~st_q.s1.neg, a_seg, a_sh[STEP_W-1:0]} ^ inv_mask(st_q.s1.inv);

        case (st_q.s1.fmt)
            FMT_MULAW: code_c = {{PAD_W{1'b0}}, mu_code};
            FMT_ALAW:  code_c = {{PAD_W{1'b0}}, a_code};
            FMT_LIN16: code_c = st_q.s1.raw;
            default:   code_c = {{PAD_W{1'b0}}, st_q.s1.raw[SMP_W-1 -: LAW_W]};
        endcase

        if (adv) begin
            st_d.s2.v    = st_q.s1.v;
            st_d.s2.fmt  = st_q.s1.fmt;
            st_d.s2.neg  = st_q.s1.neg;
            st_d.s2.data = code_c;
            st_d.s1.v      = in_valid_i;
            st_d.s1.fmt    = fmt_e'(fmt_i);
            st_d.s1.inv    = inv_i;
            st_d.s1.neg    = in_data_i[SMP_W-1];
            st_d.s1.mu_mag = mu_bias[MU_MAG_W-1:0];
            st_d.s1.a_mag  = a_abs[A_MAG_W-1:0];
            st_d.s1.raw    = in_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready_o  = adv;
    assign out_valid_o = st_q.s2.v;
    assign out_data_o  = st_q.s2.data;

    // R10: held output while stalled
    a_r10_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

    // R9: two-cycle latency with a ready consumer
    a_r9_enc_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) ##1 out_ready_i |=> out_valid_o);

    // R2: mu-law sign placement and zero upper byte
    a_r2_mu_sign: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && st_q.s2.fmt == FMT_MULAW |->
            out_data_o[LAW_W-1] == !st_q.s2.neg && out_data_o[SMP_W-1:LAW_W] == '0);
endmodule

// File: rtl/pcm_dec_pipe.sv
module pcm_dec_pipe
    import pcm_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fmt_i,
    input  logic [1:0]       inv_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [SMP_W-1:0] in_data_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [SMP_W-1:0] out_data_o
);
    typedef struct packed {
        logic              v;
        fmt_e              fmt;
        logic              sgn;
        logic [SEG_W-1:0]  seg;
        logic [STEP_W-1:0] step;
        logic [SMP_W-1:0]  raw;
    } s1_t;

    typedef struct packed {
        logic             v;
        fmt_e             fmt;
        logic [SMP_W-1:0] data;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } st_t;

    st_t st_d, st_q;

    logic             adv;
    logic [LAW_W-1:0] mu_u, a_u;
    logic [SMP_W-1:0] mu_base, mu_t, mu_lin;
    logic [SMP_W-1:0] a_base, a_t, a_lin;
    logic [SEG_W-1:0] a_segm1;
    logic [SMP_W-1:0] lin_c;

    always_comb begin
        st_d = st_q;
        adv  = !st_q.s2.v || out_ready_i;

        // stage 1: remove inversion, split fields
        mu_u = ~in_data_i[LAW_W-1:0];
        a_u  = in_data_i[LAW_W-1:0] ^ inv_mask(inv_i);

        // stage 2: expansion
        mu_base = SMP_W'({st_q.s1.step, 3'b000}) + SMP_W'(MU_DBIAS);
        mu_t    = mu_base << st_q.s1.seg;
        mu_lin  = st_q.s1.sgn ? (SMP_W'(MU_DBIAS) - mu_t) : (mu_t - SMP_W'(MU_DBIAS));

        a_base  = SMP_W'({st_q.s1.step, 4'b0000}) +
                  ((st_q.s1.seg == '0) ? SMP_W'(8) : SMP_W'(264));
        a_segm1 = st_q.s1.seg - 3'd1;
        a_t     = (st_q.s1.seg > 3'd1) ? (a_base << a_segm1) : a_base;
        a_lin   = st_q.s1.sgn ? (~a_t + 1'b1) : a_t;

        case (st_q.s1.fmt)
            FMT_MULAW: lin_c = mu_lin;
            FMT_ALAW:  lin_c = a_lin;
            FMT_LIN16: lin_c = st_q.s1.raw;
            default:   lin_c = {st_q.s1.raw[LAW_W-1:0], {PAD_W{1'b0}}};
        endcase

        if (adv) begin
            st_d.s2.v    = st_q.s1.v;
            st_d.s2.fmt  = st_q.s1.fmt;
            st_d.s2.data = lin_c;
            st_d.s1.v    = in_valid_i;
            st_d.s1.fmt  = fmt_e'(fmt_i);
            st_d.s1.raw  = in_data_i;
            case (fmt_e'(fmt_i))
                FMT_MULAW: begin
                    st_d.s1.sgn  = mu_u[LAW_W-1];
                    st_d.s1.seg  = mu_u[LAW_W-2 -: SEG_W];
                    st_d.s1.step = mu_u[STEP_W-1:0];
                end
                FMT_ALAW: begin
                    st_d.s1.sgn  = ~a_u[LAW_W-1];
                    st_d.s1.seg  = a_u[LAW_W-2 -: SEG_W];
                    st_d.s1.step = a_u[STEP_W-1:0];
                end
                default: begin
                    st_d.s1.sgn  = 1'b0;
                    st_d.s1.seg  = '0;
                    st_d.s1.step = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready_o  = adv;
    assign out_valid_o = st_q.s2.v;
    assign out_data_o  = st_q.s2.data;

    // R10: held output while stalled
    a_r10_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

    // R6: A-law expansion never yields zero
    a_r6_alaw_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && st_q.s2.fmt == FMT_ALAW |-> out_data_o != '0);

    // R5: mu-law expansion stays within its full-scale range
    a_r5_mu_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && st_q.s2.fmt == FMT_MULAW |->
            ($signed(out_data_o) <= 32124 && $signed(out_data_o) >= -32124));

    // R9: two-cycle latency with a ready consumer
    a_r9_dec_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) ##1 out_ready_i |=> out_valid_o);
endmodule

// File: rtl/pcm_fmt_conv.sv
module pcm_fmt_conv
    import pcm_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fmt_i,
    input  logic [1:0]       ainv_i,
    input  logic             tx_in_valid_i,
    output logic             tx_in_ready_o,
    input  logic [SMP_W-1:0] tx_sample_i,
    output logic             tx_out_valid_o,
    input  logic             tx_out_ready_i,
    output logic [SMP_W-1:0] tx_code_o,
    input  logic             rx_in_valid_i,
    output logic             rx_in_ready_o,
    input  logic [SMP_W-1:0] rx_code_i,
    output logic             rx_out_valid_o,
    input  logic             rx_out_ready_i,
    output logic [SMP_W-1:0] rx_sample_o
);
    pcm_enc_pipe u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt_i       (fmt_i),
        .inv_i       (ainv_i),
        .in_valid_i  (tx_in_valid_i),
        .in_ready_o  (tx_in_ready_o),
        .in_data_i   (tx_sample_i),
        .out_valid_o (tx_out_valid_o),
        .out_ready_i (tx_out_ready_i),
        .out_data_o  (tx_code_o)
    );

    pcm_dec_pipe u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt_i       (fmt_i),
        .inv_i       (ainv_i),
        .in_valid_i  (rx_in_valid_i),
        .in_ready_o  (rx_in_ready_o),
        .in_data_i   (rx_code_i),
        .out_valid_o (rx_out_valid_o),
        .out_ready_i (rx_out_ready_i),
        .out_data_o  (rx_sample_o)
    );
endmodule

// File: tb/pcm_fmt_conv_tb_top.sv
module pcm_fmt_conv_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [1:0]  fmt, ainv;
    logic        tx_iv, tx_ir, tx_ov, rx_iv, rx_ir, rx_ov, sink_rdy;
    logic [15:0] tx_s, tx_c, rx_c, rx_s;

    pcm_fmt_conv dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .ainv_i(ainv),
        .tx_in_valid_i(tx_iv), .tx_in_ready_o(tx_ir), .tx_sample_i(tx_s),
        .tx_out_valid_o(tx_ov), .tx_out_ready_i(sink_rdy), .tx_code_o(tx_c),
        .rx_in_valid_i(rx_iv), .rx_in_ready_o(rx_ir), .rx_code_i(rx_c),
        .rx_out_valid_o(rx_ov), .rx_out_ready_i(sink_rdy), .rx_sample_o(rx_s)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit bp_on = 0;
    bit done = 0;
    int exp_tx_cur, exp_rx_cur;
    string tag_tx, tag_rx;
    int    tx_q[$], rx_q[$], tx_t[$], rx_t[$];
    string tx_g[$], rx_g[$];

    function automatic int mask_of(int inv);
        if (inv == 0) return 'h55;
        if (inv == 1) return 'hFF;
        return 0;
    endfunction

    function automatic int ref_enc(int f, int inv, int v);
        int x, m, seg, step, neg;
        x = (v >= 32768) ? v - 65536 : v;
        neg = (x < 0) ? 1 : 0;
        if (f == 0) begin
            m = x >>> 2;
            if (neg == 1) m = -m;
            if (m > 8158) m = 8158;
            m = m + 33;
            seg = 0;
            for (int s = 0; s < 7; s++) if (m >= (64 << s)) seg = s + 1;
            step = (m >> (seg + 1)) & 15;
            return (~((neg << 7) | (seg << 4) | step)) & 255;
        end
        if (f == 1) begin
            m = x >>> 3;
            if (neg == 1) m = -m - 1;
            seg = 0;
            for (int s = 0; s < 7; s++) if (m >= (32 << s)) seg = s + 1;
            step = (seg < 2) ? ((m >> 1) & 15) : ((m >> seg) & 15);
            return (((1 - neg) << 7) | (seg << 4) | step) ^ mask_of(inv);
        end
        if (f == 2) return v;
        return (v >> 8) & 255;
    endfunction

    function automatic int ref_dec(int f, int inv, int c);
        int u, t, seg, r;
        if (f == 0) begin
            u = (~c) & 255;
            seg = (u >> 4) & 7;
            t = (((u & 15) << 3) + 132) << seg;
            r = ((u & 128) != 0) ? 132 - t : t - 132;
            return r & 65535;
        end
        if (f == 1) begin
            u = (c ^ mask_of(inv)) & 255;
            seg = (u >> 4) & 7;
            t = ((u & 15) << 4) + ((seg == 0) ? 8 : 264);
            if (seg > 1) t = t << (seg - 1);
            r = ((u & 128) != 0) ? t : -t;
            return r & 65535;
        end
        if (f == 2) return c;
        return (c & 255) << 8;
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor: handshakes evaluated at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            if (tx_iv && tx_ir) begin
                tx_q.push_back(exp_tx_cur); tx_g.push_back(tag_tx);
                tx_t.push_back(bp_on ? -1 : cyc);
            end
            if (rx_iv && rx_ir) begin
                rx_q.push_back(exp_rx_cur); rx_g.push_back(tag_rx);
                rx_t.push_back(bp_on ? -1 : cyc);
            end
            if (tx_ov && sink_rdy) begin
                if (tx_q.size() == 0) check("R10", "tx unexpected output", 1, 0);
                else begin
                    int e, t; string g;
                    e = tx_q.pop_front(); t = tx_t.pop_front(); g = tx_g.pop_front();
                    check(g, "tx code", int'(tx_c), e);
                    if (t >= 0) check("R9", "tx latency", cyc - t, 2);
                end
            end
            if (rx_ov && sink_rdy) begin
                if (rx_q.size() == 0) check("R10", "rx unexpected output", 1, 0);
                else begin
                    int e, t; string g;
                    e = rx_q.pop_front(); t = rx_t.pop_front(); g = rx_g.pop_front();
                    check(g, "rx sample", int'(rx_s), e);
                    if (t >= 0) check("R9", "rx latency", cyc - t, 2);
                end
            end
        end
        if (cyc > 195000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    // consumer ready: random only during the backpressure phase (R10)
    always @(posedge clk) begin
        #1;
        sink_rdy = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end

    task automatic send(input int v);
        bit tx_done, rx_done;
        int f, i;
        f = int'(fmt); i = int'(ainv);
        if (bp_on && (($urandom % 4) == 0)) begin
            tx_iv = 0; rx_iv = 0;
            @(posedge clk); #1;
        end
        exp_tx_cur = ref_enc(f, i, v);
        exp_rx_cur = ref_dec(f, i, exp_tx_cur);
        tx_s = v[15:0]; rx_c = exp_tx_cur[15:0];
        tx_iv = 1; rx_iv = 1;
        tx_done = 0; rx_done = 0;
        while (!(tx_done && rx_done)) begin
            @(negedge clk);
            if (tx_ir && tx_iv) tx_done = 1;
            if (rx_ir && rx_iv) rx_done = 1;
            @(posedge clk); #1;
            if (tx_done) tx_iv = 0;
            if (rx_done) rx_iv = 0;
        end
    endtask

    task automatic drain();
        while (tx_q.size() != 0 || rx_q.size() != 0 || tx_ov || rx_ov) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
    endtask

    task automatic phase(int f, int inv, int stride, bit bp, string ttx, string trx);
        drain();
        fmt = f[1:0]; ainv = inv[1:0]; bp_on = bp;
        tag_tx = ttx; tag_rx = trx;
        @(posedge clk); #1;
        send('h0000); send('h0001); send('hFFFF); send('h7FFF);
        send('h8000); send('hFFF8); send('h0020); send('hFFE0);
        for (int k = 0; k < 65536; k += stride) send(k);
        tx_iv = 0; rx_iv = 0;
        drain();
        bp_on = 0;
    endtask

    initial begin
        rst_n = 0; fmt = 2'd0; ainv = 2'd0; sink_rdy = 1;
        tx_iv = 0; rx_iv = 0; tx_s = '0; rx_c = '0;
        tag_tx = "R2"; tag_rx = "R5";
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1", "tx out valid after reset", int'(tx_ov), 0);
        check("R1", "rx out valid after reset", int'(rx_ov), 0);
        check("R1", "tx in ready after reset", int'(tx_ir), 1);
        check("R1", "rx in ready after reset", int'(rx_ir), 1);
        @(posedge clk); #1;

        phase(0, 0, 1,  0, "R2 mu-law encode", "R5 mu-law round trip");
        phase(0, 1, 13, 0, "R4 mu-law ignores inversion", "R4 R5 mu-law ignores inversion");
        phase(1, 0, 3,  0, "R3 R4 A-law even inversion", "R6 R4 A-law even inversion");
        phase(1, 1, 7,  0, "R3 R4 A-law full inversion", "R6 R4 A-law full inversion");
        phase(1, 2, 7,  0, "R3 R4 A-law no inversion", "R6 R4 A-law no inversion");
        phase(1, 3, 11, 0, "R3 R4 A-law inversion code 3", "R6 R4 A-law inversion code 3");
        phase(2, 0, 5,  0, "R7 linear16 tx", "R7 linear16 rx");
        phase(3, 0, 5,  0, "R8 linear8 tx", "R8 linear8 rx");
        phase(1, 0, 61, 1, "R10 A-law backpressure", "R10 A-law backpressure");
        phase(0, 2, 61, 1, "R10 mu-law backpressure", "R10 mu-law backpressure");
        phase(3, 1, 97, 1, "R10 linear8 backpressure", "R10 linear8 backpressure");

        drain();
        done = 1;
        check("R10", "tx results outstanding", tx_q.size(), 0);
        check("R10", "rx results outstanding", rx_q.size(), 0);
        summary();
    end
endmodule